// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the scan timing for a 640 by 480 display running at a pixel rate of about 25 MHz. A horizontal pixel counter steps through the 800 pixel periods of one scan line. Each time that counter finishes a line it steps a vertical line counter, which steps through the 520 lines of a frame. Three flags are decoded from the pair of counts. Two are the active-low horizontal and vertical sync pulses. The third is an active-high display-enable flag that tells the colour path when it may drive colour, and when it must drive black.

Both counts leave the block as 10-bit ports, so a pattern or colour generator downstream can use them as pixel coordinates. The flags are decoded combinationally from the counter registers, so in every cycle they describe the same position as the exported counts. A count-enable input can pause the whole raster.

The parameter `PIX_DIV` selects how the counters are stepped. At 1, the block is clocked at the pixel rate. At 4, it runs from a clock four times faster, and an internal divider lets the counters step on every fourth enabled cycle. The asynchronous reset is released through a two-stage synchronizer.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count runs 0 to H_TOTAL-1 and then wraps to 0, where H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK (defaults 640+16+96+48 = 800). It advances by exactly one on each pixel step.
- R2: While `cnt_en` is 0, both counts and all three flags hold their values.
- R3: While `rst_n` is 0, both counts are 0 and the outputs show position (0,0): `disp_en` 1, `hsync_n` 1, `vsync_n` 1. This holds even when `cnt_en` is 1. After `rst_n` rises, counting resumes within two clock edges.
- R4: The vertical count advances only on a pixel step at which the horizontal count equals H_TOTAL-1. It runs 0 to V_TOTAL-1 and then wraps, where V_TOTAL = V_ACTIVE+V_FRONT+V_SYNC+V_BACK (defaults 480+9+2+29 = 520).
- R5: `hsync_n` is 0 exactly when H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC (defaults 656 <= h < 752). Otherwise it is 1.
- R6: `vsync_n` is 0 exactly when V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC (defaults 489 <= v < 491). Otherwise it is 1.
- R7: `disp_en` is 1 exactly when h < H_ACTIVE and v < V_ACTIVE. Otherwise it is 0.
- R8: With PIX_DIV = 4, a pixel step happens only on every fourth cycle in which `cnt_en` is 1. The first pixel step after reset falls on the fourth such cycle. The vertical step uses the same pixel step.
- R9: The flags take the values that R5 to R7 give for the counts shown on `h_pos` and `v_pos` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: the pixel clock, or four times the pixel rate when PIX_DIV = 4 |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Count enable; when it is 0 the raster holds its position |
| h_pos | output | CNT_W (10) | Horizontal pixel count |
| v_pos | output | CNT_W (10) | Vertical line count |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | Display enable, 1 inside the visible area |

## Verification
Some checks run on every clock edge. The assertions cover the counter arithmetic: a step adds exactly one, a step at the last value wraps to zero, and no step means no change. They also check that the line count moves only after a line-end pixel, that the horizontal sync falls only at the first sync pixel, that display-enable never overlaps a sync pulse, and that divided pixel steps never come back to back. The exact window edges, the cycle alignment between the flags and the counts, the frame and line lengths, and the hold and reset behaviour can only be shown by the bench. It sweeps several whole frames of a reduced geometry, with and without the divider, and checks the first lines of the full 800 by 520 geometry against an arithmetic model of position.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Decoded scan flags for one raster position
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic disp_en;
  } raster_flags_t;

  // Half-open window test: lo <= x < lo + len
  function automatic logic in_window(input int unsigned x,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (x >= lo) && (x < lo + len);
  endfunction

endpackage

// File: rtl/raster_rst_sync.sv
module raster_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/raster_pix_gate.sv
module raster_pix_gate #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pix_step
);

  generate
    if (DIV <= 1) begin : g_direct
      logic unused_pins;
      assign unused_pins = clk ^ rst_n;
      assign pix_step    = en;
    end else begin : g_divided
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

      logic [DW-1:0] div_q;
      logic [DW-1:0] div_nxt;
      logic          div_last;

      assign div_last = (div_q == DIV_LAST);
      assign pix_step = en && div_last;

      always_comb begin
        div_nxt = div_q;
        if (en) begin
          div_nxt = div_last ? '0 : div_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_nxt;
      end

      // R8: divided pixel steps are never on adjacent cycles
      assert_no_back_to_back_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        pix_step |=> !pix_step
      );
    end
  endgenerate

endmodule

// File: rtl/raster_mod_counter.sv
module raster_mod_counter #(
  parameter int W       = 10,
  parameter int MODULUS = 800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         at_last
);

  localparam logic [W-1:0] LAST_V = W'(MODULUS - 1);

  logic [W-1:0] q_nxt;

  assign at_last = (q == LAST_V);

  always_comb begin
    q_nxt = q;
    if (step) begin
      q_nxt = at_last ? '0 : q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R1 R4: a step taken at the last value wraps the count to zero
  assert_wrap_to_zero_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (step && at_last) |=> (q == '0)
  );

  // R1 R4: any other step adds exactly one
  assert_single_increment_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (step && !at_last) |=> (q == $past(q) + 1'b1)
  );

  // R2: without a step the count keeps its value
  assert_hold_without_step_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !step |=> $stable(q)
  );

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int W        = 10,
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 9,
  parameter int V_SYNC   = 2
) (
  input  logic [W-1:0]  h_pos,
  input  logic [W-1:0]  v_pos,
  output raster_flags_t flags
);

  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int VS_START = V_ACTIVE + V_FRONT;

  always_comb begin
    flags.hsync_n = !in_window(32'(h_pos), HS_START, H_SYNC);
    flags.vsync_n = !in_window(32'(v_pos), VS_START, V_SYNC);
    flags.disp_en = (32'(h_pos) < H_ACTIVE) && (32'(v_pos) < V_ACTIVE);
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 9,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 29,
  parameter int PIX_DIV  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] h_pos,
  output logic [CNT_W-1:0] v_pos,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             disp_en
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam logic [CNT_W-1:0] H_LAST_V   = CNT_W'(H_TOTAL - 1);
  localparam logic [CNT_W-1:0] HS_START_V = CNT_W'(H_ACTIVE + H_FRONT);
  localparam logic [CNT_W-1:0] VS_START_V = CNT_W'(V_ACTIVE + V_FRONT);

  logic          rst_n_sync;
  logic          pix_step;
  logic          h_last;
  logic          v_last;
  logic          v_step;
  raster_flags_t flags;

  raster_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  raster_pix_gate #(.DIV(PIX_DIV)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .en       (cnt_en),
    .pix_step (pix_step)
  );

  raster_mod_counter #(.W(CNT_W), .MODULUS(H_TOTAL)) u_hcnt (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step    (pix_step),
    .q       (h_pos),
    .at_last (h_last)
  );

  // The line counter steps on the same qualified pixel step as the pixel counter
  assign v_step = pix_step && h_last;

  raster_mod_counter #(.W(CNT_W), .MODULUS(V_TOTAL)) u_vcnt (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step    (v_step),
    .q       (v_pos),
    .at_last (v_last)
  );

  raster_decode #(
    .W(CNT_W), .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC)
  ) u_dec (
    .h_pos (h_pos),
    .v_pos (v_pos),
    .flags (flags)
  );

  assign hsync_n = flags.hsync_n;
  assign vsync_n = flags.vsync_n;
  assign disp_en = flags.disp_en;

  // R4: the line count moves only after the last pixel of a line
  assert_line_step_at_end_R4: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    (v_pos != $past(v_pos)) |-> ($past(h_pos) == H_LAST_V)
  );

  // R4: the frame wraps only from the last line at the last pixel
  assert_frame_wrap_R4: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    (v_step && v_last) |=> (v_pos == '0 && h_pos == '0)
  );

  // R5: the horizontal pulse starts only at its first pixel
  assert_hsync_start_R5: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    $fell(hsync_n) |-> (h_pos == HS_START_V)
  );

  // R6: the vertical pulse starts only at the start of its first line
  assert_vsync_start_R6: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    $fell(vsync_n) |-> (v_pos == VS_START_V && h_pos == '0)
  );

  // R7: the visible area never overlaps either sync pulse
  assert_visible_without_sync_R7: assert property (
    @(posedge clk) disable iff (!rst_n_sync)
    disp_en |-> (hsync_n && vsync_n)
  );

endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

  // Reduced geometry used for whole-frame sweeps
  localparam int SHA = 8, SHF = 2, SHS = 3, SHB = 2;
  localparam int SVA = 5, SVF = 1, SVS = 2, SVB = 2;
  localparam int SHT = SHA + SHF + SHS + SHB;
  localparam int SVT = SVA + SVF + SVS + SVB;
  // Full geometry
  localparam int FHA = 640, FHF = 16, FHS = 96, FHB = 48;
  localparam int FVA = 480, FVF = 9, FVS = 2, FVB = 29;
  localparam int FHT = FHA + FHF + FHS + FHB;
  localparam int FVT = FVA + FVF + FVS + FVB;

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_en;

  logic [9:0] s_h, s_v, f_h, f_v, d_h, d_v;
  logic s_hs, s_vs, s_de, f_hs, f_vs, f_de, d_hs, d_vs, d_de;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench models of position
  int  s_eh = 0, s_ev = 0, f_eh = 0, f_ev = 0, d_eh = 0, d_ev = 0, d_div = 0;
  bit  in_reset = 1'b1;

  always #10 clk = ~clk;

  raster_timing_gen #(
    .H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
    .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB), .PIX_DIV(1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .h_pos(s_h), .v_pos(s_v), .hsync_n(s_hs), .vsync_n(s_vs), .disp_en(s_de)
  );

  raster_timing_gen dut_full (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .h_pos(f_h), .v_pos(f_v), .hsync_n(f_hs), .vsync_n(f_vs), .disp_en(f_de)
  );

  raster_timing_gen #(
    .H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
    .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB), .PIX_DIV(4)
  ) dut_div (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .h_pos(d_h), .v_pos(d_v), .hsync_n(d_hs), .vsync_n(d_vs), .disp_en(d_de)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int sync_lvl(input int x, input int act, input int fp, input int len);
    return (x >= act + fp && x < act + fp + len) ? 0 : 1;
  endfunction

  // Advance one position model by one pixel step
  task automatic adv(inout int eh, inout int ev, input int ht, input int vt);
    if (eh == ht - 1) begin
      eh = 0;
      ev = (ev == vt - 1) ? 0 : ev + 1;
    end else begin
      eh = eh + 1;
    end
  endtask

  // Compare all three instances against their models
  task automatic check_all(input string pre);
    chk({pre, " R1 small h"}, int'(s_h), s_eh);
    chk({pre, " R4 small v"}, int'(s_v), s_ev);
    chk({pre, " R5 R9 small hsync"}, int'(s_hs), sync_lvl(s_eh, SHA, SHF, SHS));
    chk({pre, " R6 R9 small vsync"}, int'(s_vs), sync_lvl(s_ev, SVA, SVF, SVS));
    chk({pre, " R7 R9 small disp"}, int'(s_de), int'(s_eh < SHA && s_ev < SVA));
    chk({pre, " R1 full h"}, int'(f_h), f_eh);
    chk({pre, " R4 full v"}, int'(f_v), f_ev);
    chk({pre, " R5 R9 full hsync"}, int'(f_hs), sync_lvl(f_eh, FHA, FHF, FHS));
    chk({pre, " R6 R9 full vsync"}, int'(f_vs), sync_lvl(f_ev, FVA, FVF, FVS));
    chk({pre, " R7 R9 full disp"}, int'(f_de), int'(f_eh < FHA && f_ev < FVA));
    chk({pre, " R8 div h"}, int'(d_h), d_eh);
    chk({pre, " R8 div v"}, int'(d_v), d_ev);
    chk({pre, " R8 div hsync"}, int'(d_hs), sync_lvl(d_eh, SHA, SHF, SHS));
    chk({pre, " R8 div vsync"}, int'(d_vs), sync_lvl(d_ev, SVA, SVF, SVS));
    chk({pre, " R8 div disp"}, int'(d_de), int'(d_eh < SHA && d_ev < SVA));
  endtask

  task automatic models_clear();
    s_eh = 0; s_ev = 0; f_eh = 0; f_ev = 0; d_eh = 0; d_ev = 0; d_div = 0;
  endtask

  // One clock: drive at negedge, models follow the posedge, sample at next negedge
  task automatic tick(input bit en, input string pre);
    cnt_en = en;
    @(posedge clk);
    if (en && !in_reset) begin
      adv(s_eh, s_ev, SHT, SVT);
      adv(f_eh, f_ev, FHT, FVT);
      if (d_div == 3) begin
        d_div = 0;
        adv(d_eh, d_ev, SHT, SVT);
      end else begin
        d_div = d_div + 1;
      end
    end
    @(negedge clk);
    check_all(pre);
  endtask

  initial begin
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);

    // R3: reset state
    chk("R3 reset h", int'(f_h), 0);
    chk("R3 reset v", int'(f_v), 0);
    chk("R3 reset disp", int'(f_de), 1);
    chk("R3 reset hsync", int'(f_hs), 1);
    chk("R3 reset vsync", int'(f_vs), 1);

    rst_n = 1'b1;
    repeat (3) tick(1'b0, "release");
    in_reset = 1'b0;
    tick(1'b0, "idle");

    // Three full-geometry lines; many small frames, with and without divider
    for (int i = 0; i < 2450; i++) tick(1'b1, "run");

    // R2: hold while the enable is low
    begin
      int hh, hv;
      hh = int'(f_h);
      hv = int'(f_v);
      for (int i = 0; i < 20; i++) begin
        tick(1'b0, "R2 hold");
        chk("R2 hold full h", int'(f_h), hh);
        chk("R2 hold full v", int'(f_v), hv);
      end
    end

    for (int i = 0; i < 300; i++) tick(1'b1, "run2");

    // R3: reset mid-run with the enable held high
    rst_n    = 1'b0;
    in_reset = 1'b1;
    models_clear();
    #1;
    chk("R3 async h", int'(s_h), 0);
    chk("R3 async v", int'(f_v), 0);
    for (int i = 0; i < 3; i++) tick(1'b1, "R3 priority");
    rst_n = 1'b1;
    repeat (3) tick(1'b0, "R3 release");
    in_reset = 1'b0;
    for (int i = 0; i < 200; i++) tick(1'b1, "R3 resume");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule